// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit sits in front of a single-ported word memory and serves several requesters. Each requester presents an opcode, a word address and two operand words. The opcodes are plain load, plain store, Test-and-Set, Swap, Fetch-and-Add and Compare-and-Swap. The unit executes exactly one request at a time. A read-modify-write therefore runs its read and its conditional write back to back, and no other port can reach memory in between. The response returns the memory word as it was before the operation, together with a status bit. The status bit reports failure only for a Compare-and-Swap whose expected value did not match.

Requests use a valid/ready handshake on each port. A requester raises `req_valid` and holds its opcode and operands stable until the cycle in which `req_ready` is high. `req_ready` can only be high while the unit is idle. It goes to at most one port, chosen round robin among the ports that are valid in that cycle, and it may depend combinationally on `req_valid`. Responses also use valid/ready on each port. `rsp_valid` is raised only toward the port that issued the request. `rsp_data` and `rsp_ok` stay stable until that port raises `rsp_ready`. The unit accepts nothing new until the response has been taken, so a stalled consumer stalls every port.

Top module: `amu_atomic_unit`

## Requirements
- R1: `req_ready` is one-hot or zero, is high only for a port whose `req_valid` is high, and is granted round robin: the search starts at the port after the last one granted, and port 0 is searched first after reset.
- R2: From the clock edge that accepts a request until the edge that completes its response handshake, no port sees `req_ready` high, so no other request can interleave with an atomic operation.
- R3: A load (opcode 0) returns the addressed word with `rsp_ok` = 1 and leaves memory unchanged.
- R4: A store (opcode 1) writes operand A to the addressed word and returns `rsp_data` = 0 with `rsp_ok` = 1.
- R5: Test-and-Set (opcode 2) returns the old word with `rsp_ok` = 1. It writes 1 to the word only when the old word was 0.
- R6: Swap (opcode 3) writes operand A and returns the previous word with `rsp_ok` = 1.
- R7: Fetch-and-Add (opcode 4) returns the old word with `rsp_ok` = 1 and stores old plus operand A modulo 2^DW, with no overflow indication.
- R8: Compare-and-Swap (opcode 5) with operand A equal to the memory word writes operand B and returns the old word, which equals operand A, with `rsp_ok` = 1.
- R9: Compare-and-Swap with operand A not equal to the memory word performs no write and returns the current word with `rsp_ok` = 0.
- R10: `rsp_valid` is one-hot or zero and goes only to the issuing port. While it is high and `rsp_ready` is low, `rsp_valid`, `rsp_data` and `rsp_ok` hold their values.
- R11: A load or store response becomes visible after the first rising edge following the accepting edge. An atomic response becomes visible after the second rising edge, because an atomic uses one read cycle and one write cycle.
- R12: After reset every memory word reads 0 and no `rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NP | Request present, one bit per port |
| req_ready | output | NP | Request accepted this cycle, one bit per port |
| req_op | input | NP x 3 | Opcode per port (0 load, 1 store, 2 test-and-set, 3 swap, 4 fetch-and-add, 5 compare-and-swap, 6 and 7 act as load) |
| req_addr | input | NP x AW | Word address per port |
| req_opa | input | NP x DW | Operand A: store/swap data, addend, or expected value |
| req_opb | input | NP x DW | Operand B: new value for compare-and-swap |
| rsp_valid | output | NP | Response present, one bit per port |
| rsp_ready | input | NP | Response taken, one bit per port |
| rsp_data | output | DW | Old memory word (0 for store) |
| rsp_ok | output | 1 | 0 only for a failed compare-and-swap |

## Verification
The hardest case to reach is a successful Compare-and-Swap while other ports are modifying the same word. Its expected value has to match a word that keeps changing. To reach it, the random stimulus confines addresses to four words and usually takes the expected operand from the bench's own memory model at the time it drives the request. Some requests still lose the race to a competing Fetch-and-Add or Swap, so both the success and the failure outcomes occur under contention. Random low levels on `rsp_ready` keep responses stalled for several cycles while other ports wait with valid requests.

// File: rtl/amu_pkg.sv
package amu_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_TAS   = 3'd2,
    OP_SWAP  = 3'd3,
    OP_FADD  = 3'd4,
    OP_CAS   = 3'd5
  } amu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_RESP
  } amu_state_e;
endpackage

// File: rtl/amu_rr_arbiter.sv
module amu_rr_arbiter #(
  parameter int NP = 3,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] req,
  input  logic          advance,
  output logic [NP-1:0] gnt,
  output logic [PW-1:0] gnt_idx
);
  logic [PW-1:0] last_q;
  logic          found;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < NP; i++) begin
      int k;
      k = (int'(last_q) + 1 + i) % NP;
      if (!found && req[k]) begin
        found   = 1'b1;
        gnt[k]  = 1'b1;
        gnt_idx = PW'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= PW'(NP - 1);
    else if (advance) last_q <= gnt_idx;
  end
endmodule

// File: rtl/amu_rmw_alu.sv
module amu_rmw_alu
  import amu_pkg::*;
#(
  parameter int DW = 16
) (
  input  amu_op_e       op,
  input  logic [DW-1:0] old_word,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic [DW-1:0] ret_data,
  output logic          ret_ok
);
  always_comb begin
    wr_en    = 1'b0;
    wr_data  = opa;
    ret_data = old_word;
    ret_ok   = 1'b1;
    case (op)
      OP_STORE: begin
        wr_en    = 1'b1;
        ret_data = '0;
      end
      OP_TAS: begin
        wr_en   = (old_word == '0);
        wr_data = DW'(1);
      end
      OP_SWAP: wr_en = 1'b1;
      OP_FADD: begin
        wr_en   = 1'b1;
        wr_data = old_word + opa;
      end
      OP_CAS: begin
        wr_en   = (old_word == opa);
        wr_data = opb;
        ret_ok  = (old_word == opa);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/amu_word_store.sv
module amu_word_store #(
  parameter int AW = 4,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] words [DEPTH];

  assign rdata = words[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else if (we) begin
      words[addr] <= wdata;
    end
  end
endmodule

// File: rtl/amu_atomic_unit.sv
module amu_atomic_unit
  import amu_pkg::*;
#(
  parameter int NP = 3,
  parameter int AW = 4,
  parameter int DW = 16,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NP-1:0]          req_valid,
  output logic [NP-1:0]          req_ready,
  input  logic [NP-1:0][2:0]     req_op,
  input  logic [NP-1:0][AW-1:0]  req_addr,
  input  logic [NP-1:0][DW-1:0]  req_opa,
  input  logic [NP-1:0][DW-1:0]  req_opb,
  output logic [NP-1:0]          rsp_valid,
  input  logic [NP-1:0]          rsp_ready,
  output logic [DW-1:0]          rsp_data,
  output logic                   rsp_ok
);
  amu_state_e    state_q;
  amu_op_e       op_q;
  logic [PW-1:0] port_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] opa_q, opb_q, old_q, data_q;
  logic          ok_q;

  logic [NP-1:0] gnt;
  logic [PW-1:0] gnt_idx;
  logic          accept, is_idle, is_atomic;
  logic          mem_we;
  logic [DW-1:0] mem_rdata, alu_old, alu_wdata, alu_ret;
  logic          alu_we, alu_ok;

  assign is_idle   = (state_q == ST_IDLE);
  assign req_ready = is_idle ? gnt : '0;
  assign accept    = is_idle && (|gnt);
  assign is_atomic = (op_q == OP_TAS) || (op_q == OP_SWAP) ||
                     (op_q == OP_FADD) || (op_q == OP_CAS);

  amu_rr_arbiter #(.NP(NP)) arb_i (
    .clk(clk), .rst_n(rst_n), .req(req_valid), .advance(accept),
    .gnt(gnt), .gnt_idx(gnt_idx)
  );

  assign alu_old = (state_q == ST_READ) ? mem_rdata : old_q;

  amu_rmw_alu #(.DW(DW)) alu_i (
    .op(op_q), .old_word(alu_old), .opa(opa_q), .opb(opb_q),
    .wr_en(alu_we), .wr_data(alu_wdata), .ret_data(alu_ret), .ret_ok(alu_ok)
  );

  assign mem_we = ((state_q == ST_READ) && (op_q == OP_STORE)) ||
                  ((state_q == ST_WRITE) && alu_we);

  amu_word_store #(.AW(AW), .DW(DW)) mem_i (
    .clk(clk), .rst_n(rst_n), .addr(addr_q), .we(mem_we),
    .wdata(alu_wdata), .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_LOAD;
      port_q  <= '0;
      addr_q  <= '0;
      opa_q   <= '0;
      opb_q   <= '0;
      old_q   <= '0;
      data_q  <= '0;
      ok_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          op_q    <= amu_op_e'(req_op[gnt_idx]);
          port_q  <= gnt_idx;
          addr_q  <= req_addr[gnt_idx];
          opa_q   <= req_opa[gnt_idx];
          opb_q   <= req_opb[gnt_idx];
          state_q <= ST_READ;
        end
        ST_READ: begin
          old_q <= mem_rdata;
          if (is_atomic) begin
            state_q <= ST_WRITE;
          end else begin
            data_q  <= alu_ret;
            ok_q    <= alu_ok;
            state_q <= ST_RESP;
          end
        end
        ST_WRITE: begin
          data_q  <= alu_ret;
          ok_q    <= alu_ok;
          state_q <= ST_RESP;
        end
        default: if (rsp_ready[port_q]) state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rsp_valid = '0;
    if (state_q == ST_RESP) rsp_valid[port_q] = 1'b1;
  end

  assign rsp_data = data_q;
  assign rsp_ok   = ok_q;
endmodule

// File: rtl/amu_atomic_chk.sv
module amu_atomic_chk #(
  parameter int NP = 3,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NP-1:0] req_valid,
  input logic [NP-1:0] req_ready,
  input logic [NP-1:0] rsp_valid,
  input logic [NP-1:0] rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic          rsp_ok
);
  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  assert_grant_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  assert_lock_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_valid & req_ready)) |=> (req_ready == '0));

  assert_no_grant_during_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_valid) |-> (req_ready == '0));

  assert_rsp_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rsp_valid & ~rsp_ready)) |=>
      ((rsp_valid == $past(rsp_valid)) && $stable(rsp_data) && $stable(rsp_ok)));
endmodule

bind amu_atomic_unit amu_atomic_chk #(.NP(NP), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .rsp_ok(rsp_ok)
);

// File: tb/amu_atomic_unit_tb_top.sv
`timescale 1ns/1ps
module amu_atomic_unit_tb_top;
  localparam int NP = 3;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NP-1:0]         req_valid, req_ready, rsp_valid, rsp_ready;
  logic [NP-1:0][2:0]    req_op;
  logic [NP-1:0][AW-1:0] req_addr;
  logic [NP-1:0][DW-1:0] req_opa, req_opb;
  logic [DW-1:0]         rsp_data;
  logic                  rsp_ok;

  amu_atomic_unit #(.NP(NP), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_opa(req_opa), .req_opb(req_opb),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_ok(rsp_ok)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  logic          v [NP];
  logic [2:0]    opv [NP];
  logic [AW-1:0] adv [NP];
  logic [DW-1:0] av [NP], bv [NP];
  logic          rr [NP];
  logic          rnd_on = 0;
  logic          rr_rnd = 0;

  logic [DW-1:0] model [DEPTH];
  logic          pend [NP];
  logic [2:0]    pop [NP];
  logic [DW-1:0] exp_d [NP];
  logic          exp_k [NP];
  int            acc_cyc [NP];
  logic          lat_seen [NP];
  logic          hold_prev = 0;
  logic [NP-1:0] prev_rv;
  logic [DW-1:0] prev_d;
  logic          prev_k;
  int            last_g = NP - 1;

  function automatic string tag(input logic [2:0] op);
    case (op)
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8/R9";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Applies one request to the bench memory model and records its expected response.
  task automatic model_accept(input int p);
    logic [DW-1:0] old;
    old = model[adv[p]];
    exp_k[p] = 1'b1;
    exp_d[p] = old;
    case (opv[p])
      3'd1: begin model[adv[p]] = av[p]; exp_d[p] = '0; end
      3'd2: if (old == '0) model[adv[p]] = 1;
      3'd3: model[adv[p]] = av[p];
      3'd4: model[adv[p]] = old + av[p];
      3'd5: begin
        if (old == av[p]) model[adv[p]] = bv[p];
        else exp_k[p] = 1'b0;
      end
      default: ;
    endcase
  endtask

  task automatic step();
    bit any_pend;
    int win;
    logic [NP-1:0] exp_g;
    @(negedge clk);
    if (rnd_on) begin
      for (int p = 0; p < NP; p++) begin
        if (!v[p] && !pend[p] && ($urandom_range(0, 1) == 1)) begin
          v[p]   = 1'b1;
          opv[p] = 3'($urandom_range(0, 7));
          adv[p] = AW'($urandom_range(0, 3));
          bv[p]  = DW'($urandom);
          if ($urandom_range(0, 3) != 0)
            av[p] = (opv[p] == 3'd5) ? model[adv[p]] : DW'($urandom_range(0, 5));
          else
            av[p] = (opv[p] == 3'd4) ? DW'($urandom) : DW'($urandom_range(0, 5));
        end
      end
    end
    if (rr_rnd) for (int p = 0; p < NP; p++) rr[p] = ($urandom_range(0, 3) != 0);
    for (int p = 0; p < NP; p++) begin
      req_valid[p] = v[p];
      req_op[p]    = opv[p];
      req_addr[p]  = adv[p];
      req_opa[p]   = av[p];
      req_opb[p]   = bv[p];
      rsp_ready[p] = rr[p];
    end
    #1;
    cyc++;
    // R10 hold under back-pressure
    if (hold_prev) begin
      chk(rsp_valid == prev_rv, "R10", "rsp_valid held", rsp_valid, prev_rv);
      chk(rsp_data == prev_d && rsp_ok == prev_k, "R10", "rsp data held",
          {rsp_ok, rsp_data}, {prev_k, prev_d});
    end
    any_pend = 0;
    for (int p = 0; p < NP; p++) any_pend |= pend[p];
    // R1 / R2 grant rules
    exp_g = '0;
    if (!any_pend) begin
      win = -1;
      for (int i = 0; i < NP; i++) begin
        int k;
        k = (last_g + 1 + i) % NP;
        if (win < 0 && v[k]) win = k;
      end
      if (win >= 0) exp_g[win] = 1'b1;
      chk(req_ready == exp_g, "R1", "round robin grant", req_ready, exp_g);
    end else begin
      chk(req_ready == '0, "R2", "no grant while busy", req_ready, 0);
    end
    // response side
    for (int p = 0; p < NP; p++) begin
      if (rsp_valid[p] && !pend[p])
        chk(0, "R10", "rsp to non-issuing port", p, -1);
      if (pend[p] && rsp_valid[p] && !lat_seen[p]) begin
        int expl;
        expl = (pop[p] >= 3'd2 && pop[p] <= 3'd5) ? 2 : 1;
        lat_seen[p] = 1'b1;
        chk(cyc - acc_cyc[p] - 1 == expl, "R11", "response latency in edges",
            cyc - acc_cyc[p] - 1, expl);
      end
      if (pend[p] && rsp_valid[p] && rr[p]) begin
        chk(rsp_data == exp_d[p], tag(pop[p]), "rsp_data", rsp_data, exp_d[p]);
        chk(rsp_ok == exp_k[p], (pop[p] == 3'd5) ? (exp_k[p] ? "R8" : "R9") : tag(pop[p]),
            "rsp_ok", rsp_ok, exp_k[p]);
        pend[p] = 1'b0;
      end
    end
    hold_prev = |(rsp_valid & ~rsp_ready);
    prev_rv = rsp_valid;
    prev_d = rsp_data;
    prev_k = rsp_ok;
    // request side
    for (int p = 0; p < NP; p++) begin
      if (v[p] && req_ready[p]) begin
        model_accept(p);
        pend[p] = 1'b1;
        pop[p] = opv[p];
        acc_cyc[p] = cyc;
        lat_seen[p] = 1'b0;
        last_g = p;
        v[p] = 1'b0;
      end
    end
  endtask

  task automatic send(input int p, input logic [2:0] op, input logic [AW-1:0] a,
                      input logic [DW-1:0] x, input logic [DW-1:0] y);
    v[p] = 1'b1; opv[p] = op; adv[p] = a; av[p] = x; bv[p] = y;
    step();
    for (int n = 0; n < 50 && (v[p] || pend[p]); n++) step();
  endtask

  task automatic drain();
    bit busy;
    for (int n = 0; n < 200; n++) begin
      busy = 0;
      for (int p = 0; p < NP; p++) busy |= v[p] | pend[p];
      if (!busy) break;
      step();
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    void'($urandom(32'd20240611));
    for (int p = 0; p < NP; p++) begin
      v[p] = 0; opv[p] = 0; adv[p] = 0; av[p] = 0; bv[p] = 0; rr[p] = 1;
      pend[p] = 0; lat_seen[p] = 0; acc_cyc[p] = 0; exp_d[p] = 0; exp_k[p] = 0; pop[p] = 0;
    end
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    req_valid = '0; req_op = '0; req_addr = '0; req_opa = '0; req_opb = '0;
    rsp_ready = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(rsp_valid == '0, "R12", "no response after reset", rsp_valid, 0);
    chk(req_ready == '0, "R12", "no grant without valid", req_ready, 0);

    send(0, 3'd0, 4'd5, 0, 0);           // R12 / R3: zeroed word
    send(1, 3'd2, 4'd2, 0, 0);           // R5 first TAS gets 0
    send(1, 3'd2, 4'd2, 0, 0);           // R5 second TAS gets 1
    send(1, 3'd0, 4'd2, 0, 0);
    send(2, 3'd1, 4'd3, 16'hFFFE, 0);    // R4
    send(0, 3'd4, 4'd3, 16'h0003, 0);    // R7 wraps to 1
    send(0, 3'd0, 4'd3, 0, 0);
    send(1, 3'd3, 4'd3, 16'h1234, 0);    // R6
    send(1, 3'd0, 4'd3, 0, 0);
    send(2, 3'd5, 4'd3, 16'h1111, 16'h5555); // R9 mismatch
    send(2, 3'd0, 4'd3, 0, 0);
    send(2, 3'd5, 4'd3, 16'h1234, 16'h5555); // R8 match
    send(2, 3'd0, 4'd3, 0, 0);

    // R10 back-pressure on port 0
    rr[0] = 1'b0;
    v[0] = 1'b1; opv[0] = 3'd0; adv[0] = 4'd3;
    repeat (8) step();
    rr[0] = 1'b1;
    drain();

    // R1 contention: three adds at once
    for (int p = 0; p < NP; p++) begin
      v[p] = 1'b1; opv[p] = 3'd4; adv[p] = 4'd7; av[p] = 1; bv[p] = 0;
    end
    drain();
    send(0, 3'd0, 4'd7, 0, 0);
    chk(model[7] == 16'd3, "R7", "model sum after contention", model[7], 3);

    rnd_on = 1'b1;
    rr_rnd = 1'b1;
    repeat (4000) step();
    rnd_on = 1'b0;
    rr_rnd = 1'b0;
    for (int p = 0; p < NP; p++) rr[p] = 1'b1;
    drain();
    for (int i = 0; i < 4; i++) send(0, 3'd0, AW'(i), 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule